// File: doc/BRIEF.md
# Carry-Speculative Split Adder

This block adds two WIDTH-bit operands in a short clock period. It splits the operands into a lower half and an upper half, each WIDTH/2 bits wide, and adds the two halves side by side. The upper half does not wait for the lower half's carry. Its carry-in is a guess taken when the operation is accepted. The guess is normally the carry that the lower half produced in the previous completed addition, which is held in a one-bit register that is cleared by reset. As a result, the longest carry chain is only half the operand width.

When the guess matches the lower half's real carry, the result appears one cycle after acceptance. When the guess is wrong, the block raises a miss flag for one cycle and stores the real carry as the new guess. It then recomputes the upper half in one extra cycle, reusing the same upper adder. While that miss is being resolved, it refuses one new operation.

A hybrid input changes how the guess is made. When the top bits of the two lower-half operands are equal, that shared bit is itself the certain carry, so it is used directly. Only when those bits differ does the block fall back on the stored prediction.

Top module: `carry_guess_adder`

## Requirements
- R1: After reset, done_o and miss_o are 0, in_ready is 1, and {cout_o, sum_o} is 0.
- R2: Whenever done_o is 1, {cout_o, sum_o} equals the exact (WIDTH+1)-bit sum of the accepted op_a and op_b, whatever the guess was.
- R3: An operation is accepted on a rising edge where in_valid and in_ready are both 1. On a correct guess, done_o is 1 and miss_o is 0 in the cycle after the next rising edge.
- R4: On a wrong guess, three things happen in order. First, in_ready is 0 during the cycle after acceptance. Next, miss_o is 1 (with done_o 0) during the following cycle. Finally, done_o is 1 in the cycle after that. In every other cycle in_ready is 1.
- R5: In non-hybrid mode, the guess equals the carry out of bit WIDTH/2-1 from the most recently completed operation, or 0 if no operation has completed since reset. Idle cycles leave the guess unchanged.
- R6: When hybrid_en is 1 at acceptance and bit WIDTH/2-1 of op_a equals bit WIDTH/2-1 of op_b, the guess is that bit, so the operation never misses. When the two bits differ, the rule of R5 applies.
- R7: With in_valid held at 1, operations complete in acceptance order, one done_o pulse each, and in_ready is 0 for exactly one cycle per miss.
- R8: done_o and miss_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hybrid_en | input | 1 | Use the agreeing top bits of the lower halves as the carry guess when possible |
| in_valid | input | 1 | Operands are presented |
| in_ready | output | 1 | A new operation may be accepted |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum_o | output | WIDTH | Sum, valid while done_o is 1 |
| cout_o | output | 1 | Carry out of the full sum, valid while done_o is 1 |
| done_o | output | 1 | One-cycle pulse marking a finished result |
| miss_o | output | 1 | One-cycle pulse marking a wrong carry guess |

## Verification
The only internal state that outlives an operation is the stored prediction. If it holds a wrong value, the fault shows up at the very next operation whose lower-half top bits differ. That operation will show a miss pulse and a stalled ready where the bench expected a hit, or the reverse, exactly two cycles after acceptance. A wrong upper-half carry that escapes correction shows up as a sum that is off by 2^(WIDTH/2) on the done pulse. A fault in the handshake state shows up as a missing or doubled done pulse, or as a stall count that does not match the miss count, within one operation.

// File: rtl/cga_pkg.sv
package cga_pkg;

  // Carry guess for the upper half: a pair of agreeing top bits in the lower
  // half fixes the carry outright; otherwise the stored prediction decides.
  function automatic logic pick_carry(input logic a_top, input logic b_top,
                                      input logic hybrid, input logic pred);
    if (hybrid && (a_top == b_top)) return a_top;
    return pred;
  endfunction

  // One full-adder bit: returns {carry, sum}.
  function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic c);
    return {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction

endpackage

// File: rtl/cga_slice.sv
module cga_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import cga_pkg::*;

  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] r;
    assign r          = fa_bit(a[i], b[i], chain[i]);
    assign sum[i]     = r[0];
    assign chain[i+1] = r[1];
  end

  assign cout = chain[W];
endmodule

// File: rtl/cga_predictor.sv
module cga_predictor (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic true_c,
  output logic pred_q,
  output logic pred_next
);
  // The stored value becomes the real carry this cycle when an operation resolves.
  assign pred_next = upd_en ? true_c : pred_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          pred_q <= 1'b0;
    else if (upd_en && (true_c != pred_q)) pred_q <= true_c;
  end
endmodule

// File: rtl/carry_guess_adder.sv
module carry_guess_adder #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hybrid_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             done_o,
  output logic             miss_o
);
  import cga_pkg::*;

  localparam int H = WIDTH / 2;

  logic [WIDTH-1:0] a_q, b_q;
  logic             hyb_q, guess_q, busy_q, fix_q;
  logic [H-1:0]     lo_s, hi_s;
  logic             lo_c, hi_c;
  logic             pred_q, pred_next;

  // Named internal events
  logic accept, exec_miss, exec_hit, complete, guess_in;

  cga_slice #(.W(H)) u_lo (
    .a(a_q[H-1:0]), .b(b_q[H-1:0]), .cin(1'b0), .sum(lo_s), .cout(lo_c));

  cga_slice #(.W(H)) u_hi (
    .a(a_q[WIDTH-1:H]), .b(b_q[WIDTH-1:H]), .cin(guess_q), .sum(hi_s), .cout(hi_c));

  cga_predictor u_pred (
    .clk(clk), .rst_n(rst_n), .upd_en(busy_q), .true_c(lo_c),
    .pred_q(pred_q), .pred_next(pred_next));

  assign exec_miss = busy_q && (guess_q != lo_c);
  assign exec_hit  = busy_q && (guess_q == lo_c);
  assign in_ready  = !exec_miss;
  assign accept    = in_valid && in_ready;
  assign complete  = exec_hit || fix_q;
  assign guess_in  = pick_carry(op_a[H-1], op_b[H-1], hybrid_en, pred_next);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; hyb_q <= 1'b0; guess_q <= 1'b0;
      busy_q <= 1'b0; fix_q <= 1'b0;
      sum_o <= '0; cout_o <= 1'b0; done_o <= 1'b0; miss_o <= 1'b0;
    end else begin
      busy_q <= accept;
      fix_q  <= exec_miss;
      done_o <= complete;
      miss_o <= exec_miss;
      if (accept) begin
        a_q   <= op_a;
        b_q   <= op_b;
        hyb_q <= hybrid_en;
      end
      if (exec_miss)   guess_q <= lo_c;
      else if (accept) guess_q <= guess_in;
      if (complete) begin
        sum_o  <= {hi_s, lo_s};
        cout_o <= hi_c;
      end
    end
  end

  // A miss is always followed by the corrected result.
  p_miss_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |=> (done_o && !miss_o));

  // A miss cycle was preceded by a refused cycle.
  p_miss_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> $past(!in_ready));

  p_flags_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && miss_o));

  // Agreeing top bits in hybrid mode give a certain carry.
  p_hybrid_sure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hyb_q && (a_q[H-1] == b_q[H-1])) |-> (guess_q == lo_c));

  p_hit_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_hit |=> (done_o && !miss_o));

  p_idle_pred_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(pred_q));
endmodule

// File: tb/carry_guess_adder_test.sv
module carry_guess_adder_test;
  localparam int W = 6;
  localparam int H = W / 2;
  localparam int M = (1 << H) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hybrid_en = 1'b0, in_valid = 1'b0, in_ready;
  logic [W-1:0] op_a = '0, op_b = '0, sum_o;
  logic cout_o, done_o, miss_o;

  always #5 clk = ~clk;

  carry_guess_adder #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .hybrid_en(hybrid_en), .in_valid(in_valid),
    .in_ready(in_ready), .op_a(op_a), .op_b(op_b), .sum_o(sum_o),
    .cout_o(cout_o), .done_o(done_o), .miss_o(miss_o));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int hits = 0, misses = 0;
  int pred_m = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: returns expected miss and advances the prediction.
  function automatic int model_miss(input int a, input int b, input bit hy);
    int tc, at, bt, g;
    tc = ((a & M) + (b & M)) >> H;
    at = (a >> (H-1)) & 1;
    bt = (b >> (H-1)) & 1;
    g  = (hy && at == bt) ? at : pred_m;
    pred_m = tc;
    return (g != tc) ? 1 : 0;
  endfunction

  task automatic run_op(input int a, input int b, input bit hy);
    int em, full;
    bit agree;
    agree = (((a >> (H-1)) & 1) == ((b >> (H-1)) & 1));
    em    = model_miss(a, b, hy);
    full  = a + b;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4", "ready while idle", in_ready, 1);
    op_a = a[W-1:0]; op_b = b[W-1:0]; hybrid_en = hy; in_valid = 1'b1;
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(in_ready == (em == 0), "R4", "ready during execute", in_ready, em == 0);
    @(negedge clk);
    if (hy && agree) chk(!miss_o, "R6", "miss with agreeing top bits", miss_o, 0);
    if (em == 0) begin
      hits++;
      chk(done_o && !miss_o, "R3", "hit done/miss", {done_o, miss_o}, 2);
      chk({cout_o, sum_o} == full, "R2", "sum on hit", {cout_o, sum_o}, full);
    end else begin
      misses++;
      chk(miss_o && !done_o, "R5", "predicted miss flag", {done_o, miss_o}, 1);
      @(negedge clk);
      chk(done_o && !miss_o, "R4", "done after repair", {done_o, miss_o}, 2);
      chk({cout_o, sum_o} == full, "R2", "sum after repair", {cout_o, sum_o}, full);
    end
  endtask

  // Streaming monitor
  bit stream_on = 1'b0;
  int exp_q[16];
  int n_push = 0, n_got = 0, stalls = 0;

  always @(negedge clk) begin
    if (stream_on) begin
      chk(!(done_o && miss_o), "R8", "done and miss together", {done_o, miss_o}, 0);
      if (in_valid && !in_ready) stalls++;
      if (done_o) begin
        chk({cout_o, sum_o} == exp_q[n_got], "R7", "streamed result order",
            {cout_o, sum_o}, exp_q[n_got]);
        n_got++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int s_miss;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !miss_o && in_ready, "R1", "flags after reset",
        {done_o, miss_o, in_ready}, 1);
    chk({cout_o, sum_o} == 0, "R1", "sum after reset", {cout_o, sum_o}, 0);

    // R5: first operation guesses 0, so a carrying lower half must miss.
    run_op(4, 4, 1'b0);
    // R5: idle gap keeps guess 1; a carrying op now hits, a non-carrying misses.
    repeat (4) @(negedge clk);
    run_op(5, 3, 1'b0);
    run_op(1, 1, 1'b0);

    // Exhaustive sweep in both modes (R2 R3 R4 R5 R6).
    for (int hy = 0; hy < 2; hy++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          run_op(a, b, hy[0]);
    chk(hits > 0 && misses > 0, "R3", "both outcomes seen", misses, 1);

    // R7: back-to-back stream.
    @(negedge clk);
    stream_on = 1'b1;
    s_miss = 0;
    for (int i = 0; i < 12; i++) begin
      int a, b;
      a = (i * 11 + 3) % (1 << W);
      b = (i * 23 + 5) % (1 << W);
      op_a = a[W-1:0]; op_b = b[W-1:0]; hybrid_en = i[0]; in_valid = 1'b1;
      s_miss += model_miss(a, b, i[0]);
      exp_q[n_push] = a + b; n_push++;
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    stream_on = 1'b0;
    chk(n_got == 12, "R7", "done pulses in stream", n_got, 12);
    chk(stalls == s_miss, "R7", "stall cycles equal misses", stalls, s_miss);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule